// File: doc/BRIEF.md
# Dual-Loop Power-Down Sequencer

This block decides when each of a set of PLL loops (two by default) is switched off. A configuration write arrives as a single load strobe. It carries a shared mode bit and one power-down bit per loop. The block also watches a per-loop signal from the charge pump that is high while a correction pulse is in progress. For each loop it drives one power-down enable.

The stored mode selects between two kinds of entry:

- **Immediate mode:** a loaded power-down bit switches the loop off at once.
- **Deferred mode:** a loaded power-down bit is parked as a pending request. It takes effect only after the charge pump of that loop has finished its current pulse, so that no pulse is cut in half.

The mode that governs a request is the one stored by an earlier write. Software therefore writes the mode first and then sets the power-down bit. Clearing a loop's bit powers the loop back up at once and discards any pending request for it.

Top module: `pdseq_top`

## Requirements
- R1: After reset every enable is 0, no request is pending, and the stored mode is immediate (0).
- R2: Each load stores the mode bit. A request carried by a load is governed by the mode stored before that load, not by the mode bit arriving with it.
- R3: In immediate mode (stored mode 0), a load with a loop's bit at 1 raises that loop's enable at the clock edge that takes the load. This holds whatever the loop's charge-pump signal is doing.
- R4: In deferred mode (stored mode 1), a loop whose request is pending keeps its enable at 0 for as long as its charge-pump signal is high (active-high by default).
- R5: A pending deferred request raises the enable at the first clock edge at which the charge-pump signal is low. If the pulse is idle when the request is loaded, the enable rises one cycle after the load edge.
- R6: A load with a loop's bit at 0 drops that loop's enable at the load edge and cancels its pending request. A later end of pulse then has no effect.
- R7: Loops are independent. One loop's bit, pending state or charge-pump signal never changes another loop's enable.
- R8: A load with the bit at 1 for a loop that is already powered down keeps it powered down, even in deferred mode with its pulse active.
- R9: An enable is high only while the most recently loaded bit for that loop is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Configuration write strobe |
| cfg_sync_mode | input | 1 | Mode bit stored on load: 1 = deferred, 0 = immediate |
| cfg_pd | input | NUM_LOOPS | Power-down bit per loop, bit i for loop i, 1 = request off |
| cp_pulse | input | NUM_LOOPS | Per-loop charge-pump pulse in progress (active high by default) |
| pd_en | output | NUM_LOOPS | Per-loop power-down enable |

## Verification
Immediate requests are issued while the loop's pulse is high. An enable that rises at once shows that the pump is ignored in that mode.

Deferred requests are tried in two ways:

- issued during a long pulse, which separates holding from entering;
- issued with the pulse idle, which confirms the one-cycle entry.

Further patterns cover the remaining requirements:

- The write order is checked by sending a mode bit that differs from the stored one together with a request. This reveals whether the stored mode or the arriving mode is used.
- Cancelling one loop while the other is pending, and giving each loop a different pulse, separates per-loop state from shared state.
- A mid-run reset confirms that the stored mode also returns to immediate.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
   typedef enum logic [1:0] {
      LOOP_UP   = 2'd0,
      LOOP_PEND = 2'd1,
      LOOP_DOWN = 2'd2
   } loop_state_e;
endpackage

// File: rtl/pdseq_mode_reg.sv
module pdseq_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic mode_in,
   output logic mode_q
);
   // Mode stored for use by later requests; reset selects immediate entry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_q <= 1'b0;
      else if (load) mode_q <= mode_in;
   end
endmodule

// File: rtl/pdseq_cp_cond.sv
module pdseq_cp_cond #(
   parameter int NUM_LOOPS   = 2,
   parameter bit ACTIVE_LOW  = 1'b0,
   parameter int SYNC_STAGES = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOOPS-1:0] cp_raw,
   output logic [NUM_LOOPS-1:0] cp_busy
);
   logic [NUM_LOOPS-1:0] cp_norm;

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign cp_norm = ~cp_raw;
      end else begin : g_pass
         assign cp_norm = cp_raw;
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign cp_busy = cp_norm;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][NUM_LOOPS-1:0] shreg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shreg <= '0;
            end else begin
               shreg[0] <= cp_norm;
               for (int s = 1; s < SYNC_STAGES; s++) shreg[s] <= shreg[s-1];
            end
         end
         assign cp_busy = shreg[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pdseq_loop_fsm.sv
module pdseq_loop_fsm
   import pdseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic req_bit,
   input  logic sync_mode,
   input  logic cp_busy,
   output logic pd_en
);
   loop_state_e st, nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         LOOP_UP: begin
            if (load && req_bit) nxt = sync_mode ? LOOP_PEND : LOOP_DOWN;
         end
         LOOP_PEND: begin
            if (load && !req_bit)         nxt = LOOP_UP;
            else if (load && !sync_mode)  nxt = LOOP_DOWN;
            else if (!cp_busy)            nxt = LOOP_DOWN;
         end
         LOOP_DOWN: begin
            if (load && !req_bit) nxt = LOOP_UP;
         end
         default: nxt = LOOP_UP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= LOOP_UP;
      else        st <= nxt;
   end

   assign pd_en = (st == LOOP_DOWN);
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top #(
   parameter int NUM_LOOPS      = 2,
   parameter bit CP_ACTIVE_LOW  = 1'b0,
   parameter int CP_SYNC_STAGES = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 cfg_sync_mode,
   input  logic [NUM_LOOPS-1:0] cfg_pd,
   input  logic [NUM_LOOPS-1:0] cp_pulse,
   output logic [NUM_LOOPS-1:0] pd_en
);
   localparam int MAX_STAGES = 4;

   generate
      if (NUM_LOOPS < 1) begin : g_bad_loops
         $error("pdseq_top: NUM_LOOPS must be at least 1");
      end
      if (CP_SYNC_STAGES < 0 || CP_SYNC_STAGES > MAX_STAGES) begin : g_bad_stages
         $error("pdseq_top: CP_SYNC_STAGES out of range");
      end
   endgenerate

   logic                 mode_q;
   logic [NUM_LOOPS-1:0] cp_busy;

   pdseq_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .mode_in (cfg_sync_mode),
      .mode_q  (mode_q)
   );

   pdseq_cp_cond #(
      .NUM_LOOPS   (NUM_LOOPS),
      .ACTIVE_LOW  (CP_ACTIVE_LOW),
      .SYNC_STAGES (CP_SYNC_STAGES)
   ) u_cp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cp_raw  (cp_pulse),
      .cp_busy (cp_busy)
   );

   generate
      for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
         pdseq_loop_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .req_bit   (cfg_pd[i]),
            .sync_mode (mode_q),
            .cp_busy   (cp_busy[i]),
            .pd_en     (pd_en[i])
         );
      end
   endgenerate
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
   parameter int NUM_LOOPS      = 2,
   parameter bit CP_ACTIVE_LOW  = 1'b0,
   parameter int CP_SYNC_STAGES = 0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 load,
   input logic                 cfg_sync_mode,
   input logic [NUM_LOOPS-1:0] cfg_pd,
   input logic [NUM_LOOPS-1:0] cp_pulse,
   input logic [NUM_LOOPS-1:0] pd_en
);
   logic                 mode_seen;
   logic [NUM_LOOPS-1:0] req_seen;
   logic [NUM_LOOPS-1:0] cp_act;

   assign cp_act = CP_ACTIVE_LOW ? ~cp_pulse : cp_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_seen <= 1'b0;
         req_seen  <= '0;
      end else if (load) begin
         mode_seen <= cfg_sync_mode;
         req_seen  <= cfg_pd;
      end
   end

   generate
      for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_chk
         // R3
         async_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load && cfg_pd[i] && !mode_seen) |=> pd_en[i]);
         // R6
         release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load && !cfg_pd[i]) |=> !pd_en[i]);
         // R9
         req_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pd_en[i] |-> req_seen[i]);
         if (CP_SYNC_STAGES == 0) begin : g_hold
            // R4
            pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (!pd_en[i] && cp_act[i] && !(load && cfg_pd[i] && !mode_seen))
               |=> !pd_en[i]);
         end
      end
   endgenerate
endmodule

bind pdseq_top pdseq_chk #(
   .NUM_LOOPS      (NUM_LOOPS),
   .CP_ACTIVE_LOW  (CP_ACTIVE_LOW),
   .CP_SYNC_STAGES (CP_SYNC_STAGES)
) u_pdseq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .load          (load),
   .cfg_sync_mode (cfg_sync_mode),
   .cfg_pd        (cfg_pd),
   .cp_pulse      (cp_pulse),
   .pd_en         (pd_en)
);

// File: tb/pdseq_top_test.sv
module pdseq_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic       cfg_sync_mode = 1'b0;
   logic [1:0] cfg_pd = 2'b00;
   logic [1:0] cp_pulse = 2'b00;
   logic [1:0] pd_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pdseq_top uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (load),
      .cfg_sync_mode (cfg_sync_mode),
      .cfg_pd        (cfg_pd),
      .cp_pulse      (cp_pulse),
      .pd_en         (pd_en)
   );

   task automatic check(input string req, input logic [1:0] exp);
      n_checks++;
      if (pd_en !== exp) begin
         n_fail++;
         $display("FAIL %s: pd_en=%b expected %b", req, pd_en, exp);
      end
   endtask

   // Called at a negedge; returns at the next negedge with the load taken.
   task automatic write_cfg(input logic m, input logic [1:0] pd);
      load = 1'b1; cfg_sync_mode = m; cfg_pd = pd;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset", 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_async;
      cp_pulse = 2'b01;
      write_cfg(1'b0, 2'b00);
      write_cfg(1'b0, 2'b01);
      check("R3 immediate entry during pulse", 2'b01);
      write_cfg(1'b0, 2'b00);
      check("R6 release", 2'b00);
   endtask

   task automatic t_sync_hold;
      write_cfg(1'b1, 2'b00);
      cp_pulse = 2'b01;
      write_cfg(1'b1, 2'b01);
      check("R4 held at load", 2'b00);
      repeat (3) @(negedge clk);
      check("R4 held during pulse", 2'b00);
      cp_pulse = 2'b00;
      @(negedge clk);
      check("R5 entry after pulse end", 2'b01);
      cp_pulse = 2'b01;
      write_cfg(1'b1, 2'b01);
      check("R8 reload stays down", 2'b01);
      write_cfg(1'b1, 2'b00);
      check("R6 release from deferred", 2'b00);
   endtask

   task automatic t_sync_idle;
      cp_pulse = 2'b00;
      write_cfg(1'b1, 2'b10);
      check("R5 idle pulse pending one cycle", 2'b00);
      @(negedge clk);
      check("R5 idle pulse entry", 2'b10);
      write_cfg(1'b1, 2'b00);
   endtask

   task automatic t_cancel;
      cp_pulse = 2'b11;
      write_cfg(1'b1, 2'b11);
      check("R4 both pending", 2'b00);
      write_cfg(1'b1, 2'b01);
      cp_pulse = 2'b00;
      @(negedge clk);
      check("R6 cancelled loop stays up", 2'b01);
      @(negedge clk);
      check("R6 cancel persists", 2'b01);
      write_cfg(1'b1, 2'b00);
   endtask

   task automatic t_order;
      cp_pulse = 2'b01;
      write_cfg(1'b0, 2'b01);
      check("R2 stored deferred mode governs", 2'b00);
      cp_pulse = 2'b00;
      @(negedge clk);
      check("R2 deferred entry", 2'b01);
      write_cfg(1'b0, 2'b00);
      cp_pulse = 2'b01;
      write_cfg(1'b1, 2'b01);
      check("R2 stored immediate mode governs", 2'b01);
      write_cfg(1'b1, 2'b00);
   endtask

   task automatic t_indep;
      cp_pulse = 2'b10;
      write_cfg(1'b1, 2'b11);
      check("R7 both pending", 2'b00);
      @(negedge clk);
      check("R7 loop0 enters, loop1 held", 2'b01);
      cp_pulse = 2'b00;
      @(negedge clk);
      check("R7 loop1 enters", 2'b11);
   endtask

   task automatic t_mid_reset;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      cp_pulse = 2'b11;
      write_cfg(1'b0, 2'b01);
      check("R1 mode immediate after reset", 2'b01);
      write_cfg(1'b0, 2'b00);
   endtask

   initial begin
      t_reset();
      t_async();
      t_sync_hold();
      t_sync_idle();
      t_cancel();
      t_order();
      t_indep();
      t_mid_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule